// File: doc/BRIEF.md
# Read Output Drive Controller

This block sits between the storage array of a synchronous burst SRAM and its shared data bus. Each clock edge it captures the decoded cycle type, tracks which reads are in flight, and decides in every cycle whether the byte lanes are driven and with which data. Two run-time mode inputs pick the output timing. The first chooses between flow-through output, where array data goes straight to the pins, and registered pipeline output, which adds one clock of read latency. The second chooses how fast the drivers turn off after a deselect: right away (single-cycle) or one cycle later (dual-cycle).

An active-low output enable gates the lane enables with no clock in the path, so it can switch the drivers off at any moment. A read issued while it is high still moves through the pipeline in full, which makes it a dummy read. A registered sleep request clears the pipeline and keeps the bus off for as long as it stays asserted. The mode inputs are registered, so the lane enables change only at clock edges.

Top module: `rd_out_ctrl`

## Requirements
- R1: Flow-through mode (`pipe_sel`=0): a read captured at a clock edge drives every lane in the cycle that follows, and `rd_data` equals the live `arr_rdata`. All bits of `byte_oe` always carry the same value.
- R2: Pipeline mode (`pipe_sel`=1): a read captured at edge n drives the lanes in the cycle after edge n+1. `rd_data` then shows the `arr_rdata` value sampled at edge n+1. In the cycle right after edge n the read alone does not drive the lanes.
- R3: Command encoding on `cyc_cmd`: 2'b00 deselect, 2'b01 read, 2'b10 write, 2'b11 handled as deselect. With `single_dsel`=1, the lanes are off in the cycle right after a deselect is captured, in both output modes.
- R4: With `single_dsel`=0, a deselect that follows a read keeps the lanes driven for one more cycle and releases them after the next edge. In flow-through mode the lanes show the data of that last read during this extra cycle.
- R5: A write captured at an edge leaves every lane undriven in the following cycle, whatever the mode inputs are.
- R6: `oe_n` high forces `byte_oe` to zero at once, with no clock edge involved. `oe_n` low enables only lanes that the pipeline marks active. A read issued with `oe_n` high still advances the pipeline, so later cycles behave exactly as if it had been visible.
- R7: If `sleep` is sampled high at an edge, the command captured at that edge and all reads in flight are discarded, and the lanes stay off until a read issued after sleep ends reaches the output.
- R8: `pipe_sel` and `single_dsel` take effect only at clock edges. Toggling them between edges leaves `byte_oe` and `rd_data` unchanged.
- R9: While synchronous reset `rst_n` is low, and after it is released, the bus is off: `byte_oe` is zero and `rd_data` is zero.

Ports, in the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pipe_sel | input | 1 | 1 = registered pipeline output, 0 = flow-through |
| single_dsel | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| cyc_cmd | input | 2 | Decoded cycle type (see R3) |
| arr_rdata | input | NUM_BYTES*LANE_W | Read data from the array |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Sleep request, active high, sampled at the clock |
| rd_data | output | NUM_BYTES*LANE_W | Data presented to the output drivers |
| byte_oe | output | NUM_BYTES | Per-lane driver enable, active high |

## Verification
Several properties are checked on every cycle: writes and sleep keep the drive off, single-cycle deselect releases the bus at once, dual-cycle deselect holds it after a read, a pipelined drive must come from an earlier captured read, and a high `oe_n` blocks every lane. Other behaviour can only be shown by the bench's scenarios. These are the exact data on the lanes in each mode, the one-cycle hold of the last read's data under dual-cycle deselect, the fact that a dummy read leaves later cycles unchanged, and the immunity to mode toggles and `oe_n` pulses between edges. The bench sweeps every pair of mode settings with a mixed command stream and compares both ports against its own cycle model.

// File: rtl/rd_out_pkg.sv
package rd_out_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_SPARE = 2'b11
  } cyc_cmd_e;

  // Spare code behaves as a deselect.
  function automatic cyc_cmd_e decode_cmd(input logic [1:0] raw);
    case (raw)
      2'b01:   return CMD_READ;
      2'b10:   return CMD_WRITE;
      default: return CMD_DESEL;
    endcase
  endfunction

  // Drive decision for the cycle after an edge.
  // cur: command captured at that edge, prev_rd: read captured one edge earlier.
  function automatic logic drive_calc(input logic pipe, input logic scd,
                                      input cyc_cmd_e cur, input logic prev_rd);
    logic res;
    if (cur == CMD_WRITE) begin
      res = 1'b0;
    end else if (pipe) begin
      res = prev_rd && !(scd && cur == CMD_DESEL);
    end else begin
      res = (cur == CMD_READ) || (!scd && cur == CMD_DESEL && prev_rd);
    end
    return res;
  endfunction

endpackage

// File: rtl/rd_out_cfg_reg.sv
module rd_out_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic pipe_sel,
  input  logic single_dsel,
  output logic pipe_q,
  output logic scd_q
);

  // Modes are sampled only at edges, so toggles between edges cannot glitch the drive.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= 1'b1;
      scd_q  <= 1'b1;
    end else begin
      pipe_q <= pipe_sel;
      scd_q  <= single_dsel;
    end
  end

endmodule

// File: rtl/rd_out_cmd_pipe.sv
module rd_out_cmd_pipe
  import rd_out_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cyc_cmd,
  input  logic       sleep,
  output cyc_cmd_e   s1_cmd,
  output logic       s2_rd,
  output logic       sleep_q,
  output logic       s1_is_rd
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_cmd  <= CMD_DESEL;
      s2_rd   <= 1'b0;
      sleep_q <= 1'b0;
    end else if (sleep) begin
      s1_cmd  <= CMD_DESEL;
      s2_rd   <= 1'b0;
      sleep_q <= 1'b1;
    end else begin
      s1_cmd  <= decode_cmd(cyc_cmd);
      s2_rd   <= (s1_cmd == CMD_READ);
      sleep_q <= 1'b0;
    end
  end

  assign s1_is_rd = (s1_cmd == CMD_READ);

endmodule

// File: rtl/rd_out_drive_ctl.sv
module rd_out_drive_ctl
  import rd_out_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pipe_q,
  input  logic                 scd_q,
  input  cyc_cmd_e             s1_cmd,
  input  logic                 s2_rd,
  input  logic                 sleep_q,
  input  logic                 oe_n,
  output logic                 drive_act,
  output logic [NUM_BYTES-1:0] byte_oe
);

  assign drive_act = !sleep_q && drive_calc(pipe_q, scd_q, s1_cmd, s2_rd);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane_oe
    assign byte_oe[b] = drive_act & ~oe_n;
  end

  // R5
  write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_cmd == CMD_WRITE) |-> !drive_act);

  // R7
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> !drive_act);

  // R3
  scd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scd_q && s1_cmd == CMD_DESEL) |-> !drive_act);

  // R4
  dcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scd_q && !sleep_q && s1_cmd == CMD_DESEL && s2_rd) |-> drive_act);

  // R2
  pipe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_q && drive_act) |-> s2_rd);

  // R1
  flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_q && !sleep_q && s1_cmd == CMD_READ) |-> drive_act);

  // R6
  oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (byte_oe == '0));

endmodule

// File: rtl/rd_out_data_path.sv
module rd_out_data_path #(
  parameter int NUM_BYTES = 4,
  parameter int LANE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pipe_q,
  input  logic                        s1_is_rd,
  input  logic [NUM_BYTES*LANE_W-1:0] arr_rdata,
  output logic [NUM_BYTES*LANE_W-1:0] rd_data
);

  localparam int DW = NUM_BYTES * LANE_W;

  logic [DW-1:0] out_q;

  // Output register: loads the array word of the read captured at the previous edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (s1_is_rd) begin
      out_q <= arr_rdata;
    end
  end

  logic bypass;
  assign bypass = !pipe_q && s1_is_rd;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane_data
    assign rd_data[b*LANE_W +: LANE_W] = bypass ? arr_rdata[b*LANE_W +: LANE_W]
                                                : out_q[b*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/rd_out_ctrl.sv
module rd_out_ctrl
  import rd_out_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int LANE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pipe_sel,
  input  logic                        single_dsel,
  input  logic [1:0]                  cyc_cmd,
  input  logic [NUM_BYTES*LANE_W-1:0] arr_rdata,
  input  logic                        oe_n,
  input  logic                        sleep,
  output logic [NUM_BYTES*LANE_W-1:0] rd_data,
  output logic [NUM_BYTES-1:0]        byte_oe
);

  logic     pipe_q, scd_q;
  cyc_cmd_e s1_cmd;
  logic     s2_rd, sleep_q, s1_is_rd, drive_act;

  rd_out_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .single_dsel(single_dsel),
    .pipe_q(pipe_q), .scd_q(scd_q)
  );

  rd_out_cmd_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .cyc_cmd(cyc_cmd), .sleep(sleep),
    .s1_cmd(s1_cmd), .s2_rd(s2_rd), .sleep_q(sleep_q), .s1_is_rd(s1_is_rd)
  );

  rd_out_drive_ctl #(.NUM_BYTES(NUM_BYTES)) u_drv (
    .clk(clk), .rst_n(rst_n), .pipe_q(pipe_q), .scd_q(scd_q),
    .s1_cmd(s1_cmd), .s2_rd(s2_rd), .sleep_q(sleep_q), .oe_n(oe_n),
    .drive_act(drive_act), .byte_oe(byte_oe)
  );

  rd_out_data_path #(.NUM_BYTES(NUM_BYTES), .LANE_W(LANE_W)) u_data (
    .clk(clk), .rst_n(rst_n), .pipe_q(pipe_q), .s1_is_rd(s1_is_rd),
    .arr_rdata(arr_rdata), .rd_data(rd_data)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (byte_oe == '0));

endmodule

// File: tb/rd_out_ctrl_tb.sv
`timescale 1ns/100ps
module rd_out_ctrl_tb_top;

  localparam int NB = 4;
  localparam int LW = 9;
  localparam int DW = NB * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_sel = 1'b1, single_dsel = 1'b1;
  logic [1:0]    cyc_cmd = 2'b00;
  logic [DW-1:0] arr_rdata = '0;
  logic          oe_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] byte_oe;

  rd_out_ctrl #(.NUM_BYTES(NB), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .single_dsel(single_dsel),
    .cyc_cmd(cyc_cmd), .arr_rdata(arr_rdata), .oe_n(oe_n), .sleep(sleep),
    .rd_data(rd_data), .byte_oe(byte_oe)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model: 0 desel, 1 read, 2 write
  int            m_cur = 0;
  bit            m_prev_rd = 0;
  bit            m_sleep = 0;
  bit            m_pipe = 1, m_scd = 1;
  logic [DW-1:0] m_hold = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int norm(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
  endfunction

  // Model update at a rising edge, from the bench's own input copies.
  task automatic model_edge();
    if (!rst_n) begin
      m_cur = 0; m_prev_rd = 0; m_sleep = 0; m_pipe = 1; m_scd = 1; m_hold = '0;
    end else begin
      if (m_cur == 1) m_hold = arr_rdata;
      m_pipe = pipe_sel;
      m_scd  = single_dsel;
      if (sleep) begin
        m_prev_rd = 0; m_cur = 0; m_sleep = 1;
      end else begin
        m_prev_rd = (m_cur == 1); m_cur = norm(cyc_cmd); m_sleep = 0;
      end
    end
  endtask

  function automatic bit exp_drive();
    if (m_sleep) return 0;                       // R7
    if (m_cur == 2) return 0;                    // R5
    if (m_cur == 0) begin
      if (m_scd) return 0;                       // R3
      return m_prev_rd;                          // R4: one extra cycle
    end
    if (m_pipe) return m_prev_rd;                // R2: needs earlier read
    return 1;                                    // R1
  endfunction

  function automatic string tag_for();
    if (m_sleep) return "R7";
    if (m_cur == 2) return "R5";
    if (oe_n) return "R6";
    if (m_cur == 0) return m_scd ? "R3" : "R4";
    return m_pipe ? "R2" : "R1";
  endfunction

  task automatic check_ports(input string tag);
    bit d;
    logic [DW-1:0] exp_oe, exp_d;
    d = exp_drive() && !oe_n;
    exp_oe = d ? {{(DW-NB){1'b0}}, {NB{1'b1}}} : '0;
    chk(tag, {{(DW-NB){1'b0}}, byte_oe}, exp_oe);
    if (d) begin
      exp_d = (!m_pipe && m_cur == 1) ? arr_rdata : m_hold;
      chk(tag, rd_data, exp_d);
    end
  endtask

  // One cycle: edge, then new array data and checks, then next command.
  task automatic cycle(input logic [1:0] c, input bit s, input bit o, input logic [DW-1:0] a,
                       input bit pm, input bit sm);
    logic [NB-1:0] oe_snap;
    logic [DW-1:0] d_snap;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    arr_rdata = a;
    oe_n = o;
    #0.2;
    check_ports(tag_for());
    // R8: mode toggles between edges change nothing
    oe_snap = byte_oe; d_snap = rd_data;
    pipe_sel = ~pipe_sel; single_dsel = ~single_dsel;
    #0.2;
    chk("R8", {{(DW-NB){1'b0}}, byte_oe}, {{(DW-NB){1'b0}}, oe_snap});
    chk("R8", rd_data, d_snap);
    // R6: output enable acts without a clock
    oe_n = 1'b1;
    #0.2;
    chk("R6", {{(DW-NB){1'b0}}, byte_oe}, '0);
    oe_n = o;
    pipe_sel = pm; single_dsel = sm;
    cyc_cmd = c; sleep = s;
  endtask

  initial begin
    int ptn;
    // R9: reset holds bus off
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); model_edge();
      @(negedge clk); #0.2;
      chk("R9", {{(DW-NB){1'b0}}, byte_oe}, '0);
      chk("R9", rd_data, '0);
    end
    rst_n = 1'b1;
    for (int mode = 0; mode < 4; mode++) begin
      for (int k = 0; k < 320; k++) begin
        ptn = ((k >> ((k & 3) << 1)) ^ (k >> 6) ^ (k * 3)) & 3;
        cycle(2'(ptn), (k % 37) == 19, (k % 7) == 3,
              {DW{1'b0}} | ({$urandom()} * 36'd40503 + 36'(k)),
              mode[0], mode[1]);
      end
    end
    // Directed: pipeline, dual-cycle, read then deselect, then writes
    cycle(2'b01, 0, 0, 36'h0AB, 1, 0);
    cycle(2'b00, 0, 0, 36'h123, 1, 0);
    cycle(2'b10, 0, 0, 36'h456, 1, 0);
    cycle(2'b01, 0, 1, 36'h789, 0, 0);
    cycle(2'b11, 0, 0, 36'h9AB, 0, 0);
    cycle(2'b00, 0, 0, 36'hCDE, 0, 1);
    for (int i = 0; i < 3; i++) cycle(2'b00, 0, 0, 36'h0, 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule